// File: doc/BRIEF.md
# Bridge Secondary Status Register

This block is the 16-bit status register for the downstream side of a bus-to-bus bridge. Monitors on that bus report error events as single-cycle pulses. The register turns those pulses into sticky flags, and software reads them out in one word that also carries fixed capability bits. Software clears a flag by writing a one to its bit. The write port has byte enables, so a partial write can only clear bits in the bytes it enables.

The parity-related flag for data carries a qualifier. It is raised either by an internal read parity error, or by a parity-error pin assertion during a write that happens while an internal master owns the bus and parity-error response is enabled.

A target abort received on a forwarded cycle that expects a completion has a side effect. In the same cycle, the block pulses a request that sets the signaled-target-abort flag in the primary status, and a request that returns target-abort status upstream.

A build-time parameter selects a reduced variant. In that variant both parity flags are tied to zero.

Top module: `bridge_sec_status`

## Requirements
- R1: After a synchronous active-low reset, the register reads 16'h0280.
- R2: A write clears each enabled sticky bit whose data bit is 1. A 0 in the data leaves that bit unchanged.
- R3: Sticky flags are set by events on the next clock edge and hold until cleared. Bit 15 is set by a bus parity error, bit 14 by a received system error, bit 13 by a master abort on a forwarded cycle, and bit 12 by a target abort on a forwarded cycle.
- R4: When a set event and a clearing write hit the same bit in the same cycle, the bit ends up 1.
- R5: Byte enable bit 0 covers data bits 7:0 and byte enable bit 1 covers data bits 15:8. A write never clears a bit in a lane that is not enabled.
- R6: Bit 8 is set by a parity-error pin assertion during a write, but only when parity-error response is enabled and an internal master owns the bus. If any one of these three conditions is missing, bit 8 stays 0.
- R7: Bit 8 is also set by an internally detected parity error during a read, with no other condition.
- R8: Bit 11 reads 0, bits 10:9 read 01, bit 7 reads 1, and bits 6:0 read 0, whatever is written.
- R9: A target abort on a cycle that needs a completion drives both `prim_sta_tabort` and `up_tabort_ret` high in the same cycle as the event, and only for that one cycle. Without the completion qualifier both stay low, but bit 12 is still set.
- R10: With FULL_PARITY = 0, bits 15 and 8 always read 0, whatever events occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr_en | input | 1 | Write strobe for the register |
| cfg_wr_be | input | 2 | Byte enables for the write |
| cfg_wr_data | input | 16 | Write data; a 1 clears the bit |
| cfg_rd_data | output | 16 | Current register value |
| bus_par_err | input | 1 | Parity error seen on the downstream bus |
| bus_serr_rx | input | 1 | System error received on the downstream bus |
| fwd_mabort | input | 1 | Forwarded cycle was master-aborted |
| fwd_tabort | input | 1 | Forwarded cycle was target-aborted |
| fwd_needs_cmpl | input | 1 | Aborted cycle expects a completion |
| perr_resp_en | input | 1 | Parity-error response enable |
| int_master_own | input | 1 | An internal master owns the bus |
| perr_pin_seen | input | 1 | Parity-error pin asserted |
| cyc_is_write | input | 1 | Current bus cycle is a write |
| rd_par_int | input | 1 | Internal parity error detected on a read |
| prim_sta_tabort | output | 1 | Request to set signaled target abort in the primary status |
| up_tabort_ret | output | 1 | Target-abort status returned upstream |

## Verification
The assertions check on every cycle that an event sets its flag on the next edge and that a flag with no event and no clear stays the same. They also check that a clearing write with no competing event takes effect, and that the fixed capability fields never move. In addition, the side-effect pulses rise only together with a target abort and leave bit 12 set behind them, and the reduced variant keeps its parity bits at zero. The bench scenarios are what show the rest: that each of the three write-case qualifiers is required for the data-parity flag, that a write to the wrong byte lane leaves bits alone, that set wins over clear in the same cycle, and that a write of zeros has no effect.

// File: rtl/secstat_pkg.sv
package secstat_pkg;
  localparam int REG_W  = 16;
  localparam int LANE_W = 8;
  localparam int BE_W   = REG_W / LANE_W;

  // Bit positions decoded by software
  localparam int B_PAR  = 15;
  localparam int B_SERR = 14;
  localparam int B_MAB  = 13;
  localparam int B_TAB  = 12;
  localparam int B_DPD  = 8;

  // Capability constants: select timing medium (bit 9), fast back-to-back (bit 7)
  localparam logic [REG_W-1:0] FIXED_VAL = 16'h0280;

  typedef struct packed {
    logic par;
    logic serr;
    logic mab;
    logic tab;
    logic dpd;
  } sec_evt_t;

  function automatic logic [REG_W-1:0] sticky_mask(input bit full);
    logic [REG_W-1:0] m;
    m = '0;
    m[B_SERR] = 1'b1;
    m[B_MAB]  = 1'b1;
    m[B_TAB]  = 1'b1;
    if (full) begin
      m[B_PAR] = 1'b1;
      m[B_DPD] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [REG_W-1:0] lane_mask(input logic [BE_W-1:0] be);
    logic [REG_W-1:0] m;
    for (int i = 0; i < REG_W; i++) m[i] = be[i / LANE_W];
    return m;
  endfunction

  function automatic logic dpd_qualify(input logic resp_en, input logic master,
                                       input logic perr, input logic is_wr,
                                       input logic rd_int);
    return (resp_en & master & perr & is_wr) | rd_int;
  endfunction

  function automatic logic [REG_W-1:0] evt_to_vec(input sec_evt_t e);
    logic [REG_W-1:0] v;
    v = '0;
    v[B_PAR]  = e.par;
    v[B_SERR] = e.serr;
    v[B_MAB]  = e.mab;
    v[B_TAB]  = e.tab;
    v[B_DPD]  = e.dpd;
    return v;
  endfunction
endpackage

// File: rtl/secstat_qual.sv
module secstat_qual
  import secstat_pkg::*;
#(
  parameter bit FULL_PARITY = 1'b1
) (
  input  logic             bus_par_err,
  input  logic             bus_serr_rx,
  input  logic             fwd_mabort,
  input  logic             fwd_tabort,
  input  logic             fwd_needs_cmpl,
  input  logic             perr_resp_en,
  input  logic             int_master_own,
  input  logic             perr_pin_seen,
  input  logic             cyc_is_write,
  input  logic             rd_par_int,
  output logic [REG_W-1:0] set_vec,
  output logic             dpd_hit,
  output logic             tabort_cmpl
);
  sec_evt_t evt;

  assign dpd_hit     = dpd_qualify(perr_resp_en, int_master_own, perr_pin_seen,
                                   cyc_is_write, rd_par_int);
  assign tabort_cmpl = fwd_tabort & fwd_needs_cmpl;

  generate
    if (FULL_PARITY) begin : g_full
      always_comb begin
        evt.par  = bus_par_err;
        evt.dpd  = dpd_hit;
        evt.serr = bus_serr_rx;
        evt.mab  = fwd_mabort;
        evt.tab  = fwd_tabort;
      end
    end else begin : g_lite
      logic unused_par;
      assign unused_par = bus_par_err;
      always_comb begin
        evt.par  = 1'b0;
        evt.dpd  = 1'b0;
        evt.serr = bus_serr_rx;
        evt.mab  = fwd_mabort;
        evt.tab  = fwd_tabort;
      end
    end
  endgenerate

  assign set_vec = evt_to_vec(evt);
endmodule

// File: rtl/secstat_w1c.sv
module secstat_w1c
  import secstat_pkg::*;
(
  input  logic             wr_en,
  input  logic [BE_W-1:0]  wr_be,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] clr_vec
);
  always_comb begin
    clr_vec = '0;
    if (wr_en) clr_vec = wr_data & lane_mask(wr_be);
  end
endmodule

// File: rtl/secstat_sticky.sv
module secstat_sticky
  import secstat_pkg::*;
#(
  parameter logic [REG_W-1:0] MASK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] set_vec,
  input  logic [REG_W-1:0] clr_vec,
  output logic [REG_W-1:0] q
);
  logic unused_inputs;
  assign unused_inputs = ^{set_vec & ~MASK, clr_vec & ~MASK};

  generate
    for (genvar i = 0; i < REG_W; i++) begin : g_bit
      if (MASK[i]) begin : g_flop
        logic b;
        always_ff @(posedge clk) begin
          if (!rst_n)          b <= 1'b0;
          else if (set_vec[i]) b <= 1'b1;       // set wins over clear
          else if (clr_vec[i]) b <= 1'b0;
        end
        assign q[i] = b;
      end else begin : g_zero
        assign q[i] = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/bridge_sec_status.sv
module bridge_sec_status
  import secstat_pkg::*;
#(
  parameter bit FULL_PARITY = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [BE_W-1:0]  cfg_wr_be,
  input  logic [REG_W-1:0] cfg_wr_data,
  output logic [REG_W-1:0] cfg_rd_data,
  input  logic             bus_par_err,
  input  logic             bus_serr_rx,
  input  logic             fwd_mabort,
  input  logic             fwd_tabort,
  input  logic             fwd_needs_cmpl,
  input  logic             perr_resp_en,
  input  logic             int_master_own,
  input  logic             perr_pin_seen,
  input  logic             cyc_is_write,
  input  logic             rd_par_int,
  output logic             prim_sta_tabort,
  output logic             up_tabort_ret
);
  localparam logic [REG_W-1:0] STICKY = sticky_mask(FULL_PARITY);

  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] clr_vec;
  logic [REG_W-1:0] flags_q;
  logic             dpd_hit;
  logic             tabort_cmpl;

  secstat_qual #(.FULL_PARITY(FULL_PARITY)) u_qual (
    .bus_par_err   (bus_par_err),
    .bus_serr_rx   (bus_serr_rx),
    .fwd_mabort    (fwd_mabort),
    .fwd_tabort    (fwd_tabort),
    .fwd_needs_cmpl(fwd_needs_cmpl),
    .perr_resp_en  (perr_resp_en),
    .int_master_own(int_master_own),
    .perr_pin_seen (perr_pin_seen),
    .cyc_is_write  (cyc_is_write),
    .rd_par_int    (rd_par_int),
    .set_vec       (set_vec),
    .dpd_hit       (dpd_hit),
    .tabort_cmpl   (tabort_cmpl)
  );

  secstat_w1c u_w1c (
    .wr_en  (cfg_wr_en),
    .wr_be  (cfg_wr_be),
    .wr_data(cfg_wr_data),
    .clr_vec(clr_vec)
  );

  secstat_sticky #(.MASK(STICKY)) u_sticky (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_vec(set_vec),
    .clr_vec(clr_vec),
    .q      (flags_q)
  );

  assign cfg_rd_data     = flags_q | FIXED_VAL;
  assign prim_sta_tabort = tabort_cmpl;
  assign up_tabort_ret   = tabort_cmpl;
endmodule

// File: rtl/secstat_chk.sv
module secstat_chk
  import secstat_pkg::*;
#(
  parameter bit FULL_PARITY = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr_en,
  input logic [BE_W-1:0]  cfg_wr_be,
  input logic [REG_W-1:0] cfg_wr_data,
  input logic [REG_W-1:0] cfg_rd_data,
  input logic             bus_serr_rx,
  input logic             fwd_mabort,
  input logic             fwd_tabort,
  input logic             prim_sta_tabort,
  input logic             up_tabort_ret,
  input logic             dpd_hit
);
  // R3: event sets its flag on the next edge
  a_r3_serr_sets: assert property (@(posedge clk) disable iff (!rst_n)
    bus_serr_rx |=> cfg_rd_data[B_SERR]);

  // R2: clearing write with no competing event clears the bit
  a_r2_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cfg_wr_be[1] && cfg_wr_data[B_SERR] && !bus_serr_rx)
      |=> !cfg_rd_data[B_SERR]);

  // R3: without set or clear the flag holds
  a_r3_mab_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwd_mabort && !(cfg_wr_en && cfg_wr_be[1] && cfg_wr_data[B_MAB]))
      |=> $stable(cfg_rd_data[B_MAB]));

  // R8: capability fields fixed
  a_r8_fixed_fields: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_data[11:9] == 3'b001 && cfg_rd_data[7:0] == 8'h80);

  // R9: side-effect pulses appear only with a target abort and leave bit 12 set
  a_r9_pulse_needs_tabort: assert property (@(posedge clk) disable iff (!rst_n)
    (prim_sta_tabort || up_tabort_ret) |-> fwd_tabort);
  a_r9_pulse_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    prim_sta_tabort |=> cfg_rd_data[B_TAB]);

  generate
    if (FULL_PARITY) begin : g_full
      // R6 / R7: qualified data-parity event sets bit 8
      a_r6_dpd_sets: assert property (@(posedge clk) disable iff (!rst_n)
        dpd_hit |=> cfg_rd_data[B_DPD]);
    end else begin : g_lite
      // R10: parity bits stay zero in the reduced variant
      a_r10_lite_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rd_data[B_PAR] && !cfg_rd_data[B_DPD]);
    end
  endgenerate
endmodule

bind bridge_sec_status secstat_chk #(.FULL_PARITY(FULL_PARITY)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_wr_en      (cfg_wr_en),
  .cfg_wr_be      (cfg_wr_be),
  .cfg_wr_data    (cfg_wr_data),
  .cfg_rd_data    (cfg_rd_data),
  .bus_serr_rx    (bus_serr_rx),
  .fwd_mabort     (fwd_mabort),
  .fwd_tabort     (fwd_tabort),
  .prim_sta_tabort(prim_sta_tabort),
  .up_tabort_ret  (up_tabort_ret),
  .dpd_hit        (dpd_hit)
);

// File: tb/bridge_sec_status_tb.sv
module bridge_sec_status_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_be = 2'b00;
  logic [15:0] wr_data = 16'h0000;
  logic        par_err = 0, serr = 0, mab = 0, tab = 0, cmpl = 0;
  logic        resp_en = 0, own = 0, perr = 0, is_wr = 0, rd_int = 0;
  logic [15:0] rd_full, rd_lite;
  logic        sta_full, ret_full, sta_lite, ret_lite;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bridge_sec_status #(.FULL_PARITY(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(wr_en), .cfg_wr_be(wr_be),
    .cfg_wr_data(wr_data), .cfg_rd_data(rd_full),
    .bus_par_err(par_err), .bus_serr_rx(serr), .fwd_mabort(mab),
    .fwd_tabort(tab), .fwd_needs_cmpl(cmpl), .perr_resp_en(resp_en),
    .int_master_own(own), .perr_pin_seen(perr), .cyc_is_write(is_wr),
    .rd_par_int(rd_int), .prim_sta_tabort(sta_full), .up_tabort_ret(ret_full));

  bridge_sec_status #(.FULL_PARITY(1'b0)) u_dut_lite (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(wr_en), .cfg_wr_be(wr_be),
    .cfg_wr_data(wr_data), .cfg_rd_data(rd_lite),
    .bus_par_err(par_err), .bus_serr_rx(serr), .fwd_mabort(mab),
    .fwd_tabort(tab), .fwd_needs_cmpl(cmpl), .perr_resp_en(resp_en),
    .int_master_own(own), .perr_pin_seen(perr), .cyc_is_write(is_wr),
    .rd_par_int(rd_int), .prim_sta_tabort(sta_lite), .up_tabort_ret(ret_lite));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_be = 2'b00; wr_data = 16'h0000;
    par_err = 0; serr = 0; mab = 0; tab = 0; cmpl = 0;
    resp_en = 0; own = 0; perr = 0; is_wr = 0; rd_int = 0;
  endtask

  // drive at negedge, then advance one edge and settle for sampling
  task automatic step();
    @(negedge clk); idle(); #1;
  endtask

  task automatic write(input logic [1:0] be, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_be = be; wr_data = d;
    step();
  endtask

  task automatic t_reset();
    chk("R1 reset full", rd_full, 16'h0280);
    chk("R1 reset lite", rd_lite, 16'h0280);
  endtask

  task automatic t_each_event();
    @(negedge clk); par_err = 1; step();
    chk("R3 bit15 set", rd_full, 16'h8280);
    chk("R10 lite bit15 zero", rd_lite, 16'h0280);
    write(2'b10, 16'h8000);
    chk("R2 bit15 cleared", rd_full, 16'h0280);
    @(negedge clk); serr = 1; step();
    chk("R3 bit14 set", rd_full, 16'h4280);
    step(); step();
    chk("R3 bit14 sticky", rd_full, 16'h4280);
    @(negedge clk); mab = 1; step();
    chk("R3 bit13 set", rd_full, 16'h6280);
    write(2'b11, 16'h6000);
    chk("R2 bits 14,13 cleared", rd_full, 16'h0280);
    chk("R2 lite cleared", rd_lite, 16'h0280);
  endtask

  task automatic t_write_zero();
    @(negedge clk); serr = 1; mab = 1; step();
    write(2'b11, 16'h0000);
    chk("R2 zero write no effect", rd_full, 16'h6280);
    write(2'b11, 16'h2000);
    chk("R2 single bit clear", rd_full, 16'h4280);
    write(2'b11, 16'hFFFF);
    chk("R8 fixed after all-ones", rd_full, 16'h0280);
    chk("R8 lite fixed after all-ones", rd_lite, 16'h0280);
  endtask

  task automatic t_byte_lane();
    @(negedge clk); serr = 1; tab = 1; step();
    write(2'b01, 16'hFFFF);
    chk("R5 low lane leaves high bits", rd_full, 16'h5280);
    write(2'b00, 16'hFFFF);
    chk("R5 no lanes leaves bits", rd_full, 16'h5280);
    write(2'b10, 16'hFFFF);
    chk("R5 high lane clears", rd_full, 16'h0280);
  endtask

  task automatic t_set_over_clear();
    @(negedge clk); mab = 1; wr_en = 1; wr_be = 2'b10; wr_data = 16'h2000; step();
    chk("R4 set beats clear", rd_full, 16'h2280);
    write(2'b10, 16'h2000);
    chk("R4 later clear works", rd_full, 16'h0280);
  endtask

  task automatic t_dpd_write();
    @(negedge clk); own = 1; perr = 1; is_wr = 1; step();
    chk("R6 no enable no set", rd_full, 16'h0280);
    @(negedge clk); resp_en = 1; perr = 1; is_wr = 1; step();
    chk("R6 no master no set", rd_full, 16'h0280);
    @(negedge clk); resp_en = 1; own = 1; is_wr = 1; step();
    chk("R6 no perr no set", rd_full, 16'h0280);
    @(negedge clk); resp_en = 1; own = 1; perr = 1; step();
    chk("R6 read cycle no set", rd_full, 16'h0280);
    @(negedge clk); resp_en = 1; own = 1; perr = 1; is_wr = 1; step();
    chk("R6 all three set", rd_full, 16'h0380);
    chk("R10 lite bit8 zero", rd_lite, 16'h0280);
    write(2'b01, 16'h0100);
    chk("R5 bit8 not in low lane", rd_full, 16'h0380);
    write(2'b10, 16'h0100);
    chk("R6 bit8 cleared", rd_full, 16'h0280);
  endtask

  task automatic t_dpd_read();
    @(negedge clk); rd_int = 1; step();
    chk("R7 internal read parity sets", rd_full, 16'h0380);
    chk("R10 lite stays zero", rd_lite, 16'h0280);
    write(2'b10, 16'h0100);
  endtask

  task automatic t_tabort();
    @(negedge clk); tab = 1; cmpl = 1; #1;
    chk("R9 pulses same cycle", {14'd0, sta_full, ret_full}, 16'h0003);
    step();
    chk("R9 pulses one cycle", {14'd0, sta_full, ret_full}, 16'h0000);
    chk("R9 bit12 set", rd_full, 16'h1280);
    write(2'b10, 16'h1000);
    @(negedge clk); tab = 1; #1;
    chk("R9 no cmpl no pulse", {14'd0, sta_full, ret_full}, 16'h0000);
    step();
    chk("R9 bit12 set without cmpl", rd_full, 16'h1280);
    @(negedge clk); cmpl = 1; #1;
    chk("R9 cmpl alone no pulse", {14'd0, sta_lite, ret_lite}, 16'h0000);
    step();
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    t_reset();
    t_each_event();
    t_write_zero();
    t_byte_lane();
    t_set_over_clear();
    t_dpd_write();
    t_dpd_read();
    t_tabort();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule